// File: doc/BRIEF.md
# Palette Memory Byte-Pair Write Port

This block fronts a 256-entry colour table of 15-bit values. Software reaches the table through one 8-bit data register and one index register. Because a colour is wider than the data register, each entry takes two byte accesses, steered by a phase bit that flips on every data access. On the first write the byte is held in a latch. The second write joins its low seven bits with the held byte, stores the 15-bit result at the current index, and then moves the index on by one.

Reads use the same phase bit. The first read gives the low byte of the entry at the index. The second read gives a fill bit from the bus together with the top seven colour bits, and then advances the index. Writing the index register also returns the phase bit to its first state. A separate lookup port lets the pixel path fetch any entry at any time, with a registered result split into three 5-bit channels.

Top module: `palette_port`

## Requirements
- R1: After reset the index is 0, the phase bit is 0, every entry is 0, and the read data and all three lookup channels read 0.
- R2: A data write in phase 0 only stores the byte in the holding latch. No entry changes and the index stays the same.
- R3: A data write in phase 1 stores {byte[6:0], held byte} at the current index. Bit 7 of that byte is discarded.
- R4: The index goes up by one only after a phase-1 data access, and it wraps from 255 to 0.
- R5: A write to the index register loads the index and forces the phase bit to 0.
- R6: A data read in phase 0 returns bits 7:0 of the entry at the index on the next cycle. A read in phase 1 returns {fill bit, bits 14:8} and then advances the index. Reads and writes share one phase bit.
- R7: The lookup port returns the entry at the requested index one cycle later: red from bits 4:0, green from bits 9:5, blue from bits 14:10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| idxWrEn | input | 1 | Index register write strobe |
| idxWrData | input | 8 | New index value |
| dataWrEn | input | 1 | Data register write strobe |
| dataWrData | input | 8 | Byte written to the data register |
| dataRdEn | input | 1 | Data register read strobe |
| rdFillBit | input | 1 | Bit placed at the top of the high-byte read |
| dataRdData | output | 8 | Registered read byte |
| lkIdx | input | 8 | Lookup index |
| lkRed | output | 5 | Lookup red channel |
| lkGreen | output | 5 | Lookup green channel |
| lkBlue | output | 5 | Lookup blue channel |

## Verification
The assertions take for granted that at most one of the index write, data write and data read strobes is high in any cycle. An input check enforces this. The bench picks exactly one access type, or none, for each cycle, so it never breaks that rule. The lookup index is free to change every cycle, including in the same cycle as a commit to the very entry being looked up. In that case the bench expects the old contents.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int DEPTH = 256;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CH_W = 5;
  localparam int COL_W = 3 * CH_W;
  localparam int BYTE_W = 8;
  localparam int HI_W = COL_W - BYTE_W;

  typedef struct packed {
    logic latchLow;
    logic commit;
    logic rdLow;
    logic rdHigh;
  } palStrobe_t;
endpackage

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import palette_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             idxWrEn,
  input  logic [IDX_W-1:0] idxWrData,
  input  logic             dataWrEn,
  input  logic             dataRdEn,
  output palStrobe_t       strobe,
  output logic [IDX_W-1:0] curIdx
);
  logic phase;
  logic advance;

  always_comb begin
    strobe.latchLow = dataWrEn && !idxWrEn && !phase;
    strobe.commit   = dataWrEn && !idxWrEn && phase;
    strobe.rdLow    = dataRdEn && !dataWrEn && !idxWrEn && !phase;
    strobe.rdHigh   = dataRdEn && !dataWrEn && !idxWrEn && phase;
    advance         = strobe.commit || strobe.rdHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= 1'b0;
      curIdx <= '0;
    end else if (idxWrEn) begin
      phase  <= 1'b0;
      curIdx <= idxWrData;
    end else begin
      if (dataWrEn || dataRdEn) phase <= !phase;
      if (advance) curIdx <= curIdx + 1'b1;
    end
  end

  // R5
  idx_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    idxWrEn |=> (curIdx == $past(idxWrData)) && !phase);

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!idxWrEn && (dataWrEn || dataRdEn) && phase) |=> curIdx == IDX_W'($past(curIdx) + 1));

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!idxWrEn && !phase) |=> $stable(curIdx));

  // R6
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!idxWrEn && (dataWrEn || dataRdEn)) |=> phase != $past(phase));
endmodule

// File: rtl/palette_dp.sv
module palette_dp
  import palette_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  palStrobe_t       strobe,
  input  logic [IDX_W-1:0] curIdx,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic             rdFillBit,
  input  logic [IDX_W-1:0] lkIdx,
  output logic [BYTE_W-1:0] rdByte,
  output logic [CH_W-1:0]  lkRed,
  output logic [CH_W-1:0]  lkGreen,
  output logic [CH_W-1:0]  lkBlue
);
  logic [COL_W-1:0]  colMem [DEPTH];
  logic [BYTE_W-1:0] heldByte;
  logic [COL_W-1:0]  lkWord;
  logic [COL_W-1:0]  curWord;

  assign curWord = colMem[curIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) colMem[i] <= '0;
      heldByte <= '0;
      rdByte   <= '0;
      lkWord   <= '0;
    end else begin
      lkWord <= colMem[lkIdx];
      if (strobe.latchLow) heldByte <= wrByte;
      if (strobe.commit) colMem[curIdx] <= {wrByte[HI_W-1:0], heldByte};
      if (strobe.rdLow) rdByte <= curWord[BYTE_W-1:0];
      else if (strobe.rdHigh) rdByte <= {rdFillBit, curWord[COL_W-1:BYTE_W]};
    end
  end

  assign lkRed   = lkWord[CH_W-1:0];
  assign lkGreen = lkWord[2*CH_W-1:CH_W];
  assign lkBlue  = lkWord[3*CH_W-1:2*CH_W];

  // R2
  held_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchLow |=> heldByte == $past(wrByte));

  // R3
  commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> colMem[$past(curIdx)] == {$past(wrByte[HI_W-1:0]), $past(heldByte)});

  // R7
  lookup_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> {lkBlue, lkGreen, lkRed} == $past(colMem[lkIdx]));

  // R6
  rd_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdHigh |=> rdByte[BYTE_W-1] == $past(rdFillBit));
endmodule

// File: rtl/palette_port.sv
module palette_port
  import palette_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              idxWrEn,
  input  logic [IDX_W-1:0]  idxWrData,
  input  logic              dataWrEn,
  input  logic [BYTE_W-1:0] dataWrData,
  input  logic              dataRdEn,
  input  logic              rdFillBit,
  output logic [BYTE_W-1:0] dataRdData,
  input  logic [IDX_W-1:0]  lkIdx,
  output logic [CH_W-1:0]   lkRed,
  output logic [CH_W-1:0]   lkGreen,
  output logic [CH_W-1:0]   lkBlue
);
  palStrobe_t       strobe;
  logic [IDX_W-1:0] curIdx;

  palette_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .idxWrEn(idxWrEn), .idxWrData(idxWrData),
    .dataWrEn(dataWrEn), .dataRdEn(dataRdEn), .strobe(strobe), .curIdx(curIdx)
  );

  palette_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curIdx(curIdx),
    .wrByte(dataWrData), .rdFillBit(rdFillBit), .lkIdx(lkIdx),
    .rdByte(dataRdData), .lkRed(lkRed), .lkGreen(lkGreen), .lkBlue(lkBlue)
  );

  // Input rule: only one access strobe per cycle
  one_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({idxWrEn, dataWrEn, dataRdEn}));
endmodule

// File: tb/palette_port_bench.sv
module palette_port_bench;
  logic clk = 0;
  logic rstN = 0;
  logic idxWrEn = 0, dataWrEn = 0, dataRdEn = 0, rdFillBit = 0;
  logic [7:0] idxWrData = 0, dataWrData = 0, lkIdx = 0;
  logic [7:0] dataRdData;
  logic [4:0] lkRed, lkGreen, lkBlue;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string curReq = "R1";

  // reference model state
  int mPhase, mIdx, mHeld, mRd, mLk;
  int mMem[256];

  palette_port u_palette_port (
    .clk(clk), .rstN(rstN), .idxWrEn(idxWrEn), .idxWrData(idxWrData),
    .dataWrEn(dataWrEn), .dataWrData(dataWrData), .dataRdEn(dataRdEn),
    .rdFillBit(rdFillBit), .dataRdData(dataRdData), .lkIdx(lkIdx),
    .lkRed(lkRed), .lkGreen(lkGreen), .lkBlue(lkBlue)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mIdx = 0; mHeld = 0; mRd = 0; mLk = 0;
      for (int i = 0; i < 256; i++) mMem[i] = 0;
    end else begin
      mLk = mMem[lkIdx];
      if (idxWrEn) begin
        mIdx = idxWrData; mPhase = 0;
      end else if (dataWrEn) begin
        if (mPhase == 0) mHeld = dataWrData;
        else begin
          mMem[mIdx] = ((dataWrData & 8'h7f) << 8) | mHeld;
          mIdx = (mIdx + 1) % 256;
        end
        mPhase = 1 - mPhase;
      end else if (dataRdEn) begin
        if (mPhase == 0) mRd = mMem[mIdx] & 8'hff;
        else begin
          mRd = (int'(rdFillBit) << 7) | (mMem[mIdx] >> 8);
          mIdx = (mIdx + 1) % 256;
        end
        mPhase = 1 - mPhase;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    check(curReq, "read byte", dataRdData, mRd);
    check((curReq == "R1") ? "R1" : "R7", "red", lkRed, mLk & 31);
    check((curReq == "R1") ? "R1" : "R7", "green", lkGreen, (mLk >> 5) & 31);
    check((curReq == "R1") ? "R1" : "R7", "blue", lkBlue, (mLk >> 10) & 31);
  endtask

  task automatic idle();
    idxWrEn = 0; dataWrEn = 0; dataRdEn = 0;
  endtask

  // one cycle: drive at negedge, compare at next negedge
  task automatic step();
    @(negedge clk);
    compareAll();
  endtask

  task automatic doIdx(int v);
    idle(); idxWrEn = 1; idxWrData = 8'(v); step(); idle();
  endtask

  task automatic doWr(int v);
    idle(); dataWrEn = 1; dataWrData = 8'(v); step(); idle();
  endtask

  task automatic doRd(bit f);
    idle(); dataRdEn = 1; rdFillBit = f; step(); idle();
  endtask

  task automatic look(int i);
    idle(); lkIdx = 8'(i); step();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    curReq = "R1";
    for (int i = 0; i < 4; i++) look(i * 85);

    // R2: first byte only latched, entry unchanged
    curReq = "R2";
    doIdx(5);
    doWr(8'h3A);
    look(5);
    check("R2", "entry after first byte", {lkBlue, lkGreen, lkRed}, 0);

    // R3: second byte commits, bit 7 discarded -> 0x7F3A
    curReq = "R3";
    doWr(8'hFF);
    look(5);
    step();
    check("R3", "red", lkRed, 5'h1A);
    check("R3", "green", lkGreen, 5'h19);
    check("R3", "blue", lkBlue, 5'h1F);

    // R4: advance and wrap 255 -> 0
    curReq = "R4";
    doIdx(255);
    doWr(8'h11); doWr(8'h22);
    doWr(8'h33); doWr(8'h44);
    look(0); step();
    check("R4", "wrapped entry 0", {lkBlue, lkGreen, lkRed}, 15'h4433);
    look(255); step();
    check("R4", "entry 255", {lkBlue, lkGreen, lkRed}, 15'h2211);

    // R5: index write clears a pending phase
    curReq = "R5";
    doIdx(9);
    doWr(8'hAA);
    doIdx(10);
    doWr(8'h55); doWr(8'h01);
    look(10); step();
    check("R5", "entry 10 after phase clear", {lkBlue, lkGreen, lkRed}, 15'h0155);
    look(9); step();
    check("R5", "entry 9 untouched", {lkBlue, lkGreen, lkRed}, 0);

    // R6: read back pair, fill bit, index advance
    curReq = "R6";
    doIdx(5);
    doRd(1'b1); step();
    check("R6", "low byte", dataRdData, 8'h3A);
    doRd(1'b1); step();
    check("R6", "high byte", dataRdData, 8'hFF);
    doRd(1'b0); step();
    check("R6", "next entry low", dataRdData, 8'h00);

    // mixed traffic, compared every cycle
    curReq = "R6";
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom_range(0, 9);
      idle();
      lkIdx = 8'($urandom);
      if (op == 0) begin idxWrEn = 1; idxWrData = 8'($urandom); end
      else if (op < 6) begin dataWrEn = 1; dataWrData = 8'($urandom); end
      else if (op < 8) begin dataRdEn = 1; rdFillBit = 1'($urandom); end
      step();
    end
    idle();
    for (int i = 0; i < 256; i++) look(i);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule